// File: doc/BRIEF.md
# Weighted Multi-Priority Command Arbiter

This block merges memory commands from four requesting ports into the single command queue of a memory controller. Each cycle it sorts the live requests into four priority levels, lets the ports inside each level compete on programmable weights backed by per-port credit counters, and forwards the candidate of the most urgent level. The decision, the port number and the chosen command leave through registers one cycle after the inputs were sampled.

A port raises `req_valid` with its priority and command and holds them until it sees its `gnt` bit. The grant pulse is the acceptance of that command. In the cycle its grant is high, the port's request is not considered, so it has one cycle to drop the request or present the next one. The downstream queue applies back-pressure through `queue_full`. While it is high, nothing is accepted and no arbitration state moves. The output side is a valid-only stream (`out_valid` with `out_port`/`out_cmd`): the queue must take every beat it did not block in the previous cycle. Two pairs of neighbouring ports, 0/1 and 2/3, can be linked so that they draw on one shared credit budget.

Top module: `wmp_cmd_arbiter`

## Requirements
- R1: After reset, `gnt` is all zero and `out_valid` is low, and every credit counter is empty.
- R2: A grant decided on the inputs sampled at one rising edge appears at the next clock output. It is one-hot in `gnt`, `out_valid` is high, `out_port` carries the index of the set `gnt` bit and `out_cmd` carries that port's command as it was sampled.
- R3: When `queue_full` is sampled high, the next cycle shows no grant and `out_valid` low, and no credit counter changes.
- R4: Priority values run 0 (most urgent) to 3. The grant always goes to a port holding the smallest priority value among the ports that are considered.
- R5: Every grant takes one credit from the winner's counter. Within the winning level, ports whose counter is non-zero are preferred. If no candidate of that level has credit, the counters of all its candidates are reloaded with their weights, and the winner's counter is then decremented.
- R6: Among the preferred candidates of a level, the port with the larger effective weight wins.
- R7: When effective weights are equal, the port with the smaller 2-bit order rank (`cfg_rank`, field p at bits [2p+1:2p]) wins. Equal ranks fall back to the lower port index.
- R8: A programmed weight of zero (`cfg_weight` field p at bits [8p+7:8p]) behaves exactly as a weight of one.
- R9: With `cfg_link[k]` set, ports 2k and 2k+1 both use the weight and the credit counter of port 2k, and a grant to either of them decrements that shared counter.
- R10: A port whose `gnt` bit is high in the current cycle is ignored by the decision made at the next edge, so one port is never granted on two consecutive cycles.
- R11: Without any considered request, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Per-port request valid |
| req_prio | input | 8 | Per-port priority, 2 bits per port, 0 most urgent |
| req_cmd | input | 64 | Per-port command, 16 bits per port |
| cfg_weight | input | 32 | Per-port weight, 8 bits per port, 0 counts as 1 |
| cfg_rank | input | 8 | Per-port tie-break rank, 2 bits per port, smaller wins |
| cfg_link | input | 2 | Bit k links ports 2k and 2k+1 |
| queue_full | input | 1 | Downstream queue cannot accept a command |
| gnt | output | 4 | Registered one-hot grant, acceptance pulse per port |
| out_valid | output | 1 | A command is forwarded this cycle |
| out_port | output | 2 | Index of the granted port |
| out_cmd | output | 16 | Command forwarded to the queue |

## Verification
Every result of this block is due exactly one edge after the stimulus it depends on. The grant, valid, port and command registers load at the rising edge that samples the requests, the full flag and the configuration. The bench therefore drives inputs at a falling edge, computes the expected outcome from its own credit model at that moment, and compares the outputs at the following falling edge. Credit effects (reloads, shared pair budgets, frozen state under `queue_full`) only appear in later decisions, so they are judged through the grant sequence over the following cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int unsigned ARB_PORTS = 4;
  localparam int unsigned ARB_LEVELS = 4;
  localparam int unsigned ARB_WEIGHT_W = 8;
  localparam int unsigned ARB_CMD_W = 16;

  // Index of the port whose credit and weight a port uses.
  function automatic int unsigned credit_owner(input int unsigned port, input logic linked);
    return linked ? (port - (port % 2)) : port;
  endfunction

endpackage

// File: rtl/arb_weight_map.sv
module arb_weight_map #(
  parameter int unsigned N  = 4,
  parameter int unsigned WW = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*WW-1:0] cfg_weight,
  input  logic [N/2-1:0]  cfg_link,
  output logic [N*WW-1:0] eff_weight,
  output logic [N*IW-1:0] owner
);
  import arb_pkg::*;

  for (genvar p = 0; p < N; p++) begin : g_port
    localparam int unsigned PAIR_LO = p - (p % 2);
    logic linked;
    logic [WW-1:0] raw;
    assign linked = cfg_link[p/2];
    always_comb begin
      raw = linked ? cfg_weight[PAIR_LO*WW +: WW] : cfg_weight[p*WW +: WW];
      eff_weight[p*WW +: WW] = (raw == '0) ? WW'(1) : raw;
      owner[p*IW +: IW] = IW'(credit_owner(p, linked));
    end
  end
endmodule

// File: rtl/arb_group_pick.sv
module arb_group_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned WW    = 8,
  parameter int unsigned PW    = 2,
  parameter int unsigned LEVEL = 0,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    live,
  input  logic [N*PW-1:0] prio,
  input  logic [N-1:0]    has_credit,
  input  logic [N*WW-1:0] eff_weight,
  input  logic [N*IW-1:0] rank,
  output logic [N-1:0]    members,
  output logic            found,
  output logic            starved,
  output logic [IW-1:0]   winner
);
  logic [N-1:0]  credited;
  logic [N-1:0]  eligible;
  logic [WW-1:0] best_w;
  logic [IW-1:0] best_r;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      members[i] = live[i] && (prio[i*PW +: PW] == PW'(LEVEL));
    end
    credited = members & has_credit;
    eligible = (|credited) ? credited : members;
    found    = |members;
    starved  = found && !(|credited);
    winner   = '0;
    best_w   = '0;
    best_r   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      // Scan from the top so that a lower index wins a full tie.
      if (eligible[i]) begin
        if ((eff_weight[i*WW +: WW] > best_w) ||
            ((eff_weight[i*WW +: WW] == best_w) && (rank[i*IW +: IW] <= best_r)) ||
            (best_w == '0)) begin
          best_w = eff_weight[i*WW +: WW];
          best_r = rank[i*IW +: IW];
          winner = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/arb_credit_bank.sv
module arb_credit_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned WW = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [IW-1:0]   win_owner,
  input  logic [N-1:0]    reload_mask,
  input  logic [N*WW-1:0] reload_val,
  output logic [N-1:0]    nonzero
);
  logic [WW-1:0] credit [N];

  for (genvar p = 0; p < N; p++) begin : g_ctr
    logic [WW-1:0] base;
    always_comb begin
      base = reload_mask[p] ? reload_val[p*WW +: WW] : credit[p];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        credit[p] <= '0;
      end else if (fire) begin
        if (win_owner == IW'(p)) begin
          credit[p] <= base - WW'(1);
        end else begin
          credit[p] <= base;
        end
      end
    end
    assign nonzero[p] = (credit[p] != '0);
  end
endmodule

// File: rtl/wmp_cmd_arbiter.sv
module wmp_cmd_arbiter #(
  parameter int unsigned N_PORTS  = 4,
  parameter int unsigned N_LEVELS = 4,
  parameter int unsigned WEIGHT_W = 8,
  parameter int unsigned CMD_W    = 16,
  localparam int unsigned IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned PW = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS-1:0]       req_valid,
  input  logic [N_PORTS*PW-1:0]    req_prio,
  input  logic [N_PORTS*CMD_W-1:0] req_cmd,
  input  logic [N_PORTS*WEIGHT_W-1:0] cfg_weight,
  input  logic [N_PORTS*IW-1:0]    cfg_rank,
  input  logic [N_PORTS/2-1:0]     cfg_link,
  input  logic                     queue_full,
  output logic [N_PORTS-1:0]       gnt,
  output logic                     out_valid,
  output logic [IW-1:0]            out_port,
  output logic [CMD_W-1:0]         out_cmd
);
  logic [N_PORTS*WEIGHT_W-1:0] eff_weight;
  logic [N_PORTS*IW-1:0]       owner;
  logic [N_PORTS-1:0]          owner_nz;
  logic [N_PORTS-1:0]          port_credit;
  logic [N_PORTS-1:0]          live;

  logic [N_PORTS-1:0] grp_members [N_LEVELS];
  logic [N_LEVELS-1:0] grp_found;
  logic [N_LEVELS-1:0] grp_starved;
  logic [IW-1:0]       grp_winner [N_LEVELS];

  logic              any_found;
  logic [PW-1:0]     sel_level;
  logic [IW-1:0]     sel_port;
  logic              fire;
  logic [N_PORTS-1:0] reload_mask;

  logic [N_PORTS-1:0] gnt_q;
  logic               valid_q;
  logic [IW-1:0]      port_q;
  logic [CMD_W-1:0]   cmd_q;

  arb_weight_map #(.N(N_PORTS), .WW(WEIGHT_W)) u_wmap (
    .cfg_weight(cfg_weight),
    .cfg_link  (cfg_link),
    .eff_weight(eff_weight),
    .owner     (owner)
  );

  // Ports granted this cycle are still holding their old request.
  assign live = req_valid & ~gnt_q;

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      port_credit[p] = owner_nz[owner[p*IW +: IW]];
    end
  end

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_level
    arb_group_pick #(
      .N(N_PORTS), .WW(WEIGHT_W), .PW(PW), .LEVEL(g)
    ) u_pick (
      .live      (live),
      .prio      (req_prio),
      .has_credit(port_credit),
      .eff_weight(eff_weight),
      .rank      (cfg_rank),
      .members   (grp_members[g]),
      .found     (grp_found[g]),
      .starved   (grp_starved[g]),
      .winner    (grp_winner[g])
    );
  end

  // Final stage: most urgent non-empty level.
  always_comb begin
    any_found = 1'b0;
    sel_level = '0;
    sel_port  = '0;
    for (int g = N_LEVELS - 1; g >= 0; g--) begin
      if (grp_found[g]) begin
        any_found = 1'b1;
        sel_level = PW'(g);
        sel_port  = grp_winner[g];
      end
    end
    fire = any_found && !queue_full;
    reload_mask = '0;
    if (grp_starved[sel_level]) begin
      for (int p = 0; p < N_PORTS; p++) begin
        if (grp_members[sel_level][p]) begin
          reload_mask[owner[p*IW +: IW]] = 1'b1;
        end
      end
    end
  end

  arb_credit_bank #(.N(N_PORTS), .WW(WEIGHT_W)) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .win_owner  (owner[sel_port*IW +: IW]),
    .reload_mask(reload_mask),
    .reload_val (eff_weight),
    .nonzero    (owner_nz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q   <= '0;
      valid_q <= 1'b0;
      port_q  <= '0;
      cmd_q   <= '0;
    end else begin
      valid_q <= fire;
      gnt_q   <= fire ? (N_PORTS'(1) << sel_port) : '0;
      if (fire) begin
        port_q <= sel_port;
        cmd_q  <= req_cmd[sel_port*CMD_W +: CMD_W];
      end
    end
  end

  assign gnt       = gnt_q;
  assign out_valid = valid_q;
  assign out_port  = port_q;
  assign out_cmd   = cmd_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 2,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_valid,
  input logic [N*PW-1:0] req_prio,
  input logic          queue_full,
  input logic [N-1:0]  gnt,
  input logic          out_valid,
  input logic [IW-1:0] out_port
);
  logic [N-1:0]    live_d;
  logic [N*PW-1:0] prio_d;
  logic [PW-1:0]   min_now;

  always_comb begin
    min_now = '1;
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && !gnt[i] && (req_prio[i*PW +: PW] < min_now)) begin
        min_now = req_prio[i*PW +: PW];
      end
    end
  end

  logic [PW-1:0] min_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_d <= '0;
      prio_d <= '0;
      min_d  <= '0;
    end else begin
      live_d <= req_valid & ~gnt;
      prio_d <= req_prio;
      min_d  <= min_now;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_port_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (gnt[out_port] && $countones(gnt) == 1));
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |=> !out_valid);
  p_most_urgent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (prio_d[out_port*PW +: PW] == min_d));
  p_no_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !(out_valid && out_port == $past(out_port)));
  p_granted_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> live_d[out_port]);
endmodule

bind wmp_cmd_arbiter arb_checker #(.N(N_PORTS), .PW(PW)) u_arb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_prio  (req_prio),
  .queue_full(queue_full),
  .gnt       (gnt),
  .out_valid (out_valid),
  .out_port  (out_port)
);

// File: tb/wmp_cmd_arbiter_test.sv
`timescale 1ns/1ps
module wmp_cmd_arbiter_test;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  req = '0;
  logic [1:0]  prio [NP];
  logic [15:0] cmd  [NP];
  logic [7:0]  wt   [NP];
  logic [1:0]  rank [NP];
  logic [1:0]  link = '0;
  logic        full = 1'b0;

  logic [7:0]  req_prio_f;
  logic [63:0] req_cmd_f;
  logic [31:0] wt_f;
  logic [7:0]  rank_f;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      req_prio_f[i*2 +: 2] = prio[i];
      req_cmd_f[i*16 +: 16] = cmd[i];
      wt_f[i*8 +: 8] = wt[i];
      rank_f[i*2 +: 2] = rank[i];
    end
  end

  logic [3:0]  gnt;
  logic        out_valid;
  logic [1:0]  out_port;
  logic [15:0] out_cmd;

  wmp_cmd_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .req_prio(req_prio_f),
    .req_cmd(req_cmd_f), .cfg_weight(wt_f), .cfg_rank(rank_f),
    .cfg_link(link), .queue_full(full), .gnt(gnt), .out_valid(out_valid),
    .out_port(out_port), .out_cmd(out_cmd)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  int cred [NP];
  bit gprev [NP];
  bit          e_valid;
  int          e_port;
  logic [15:0] e_cmd;

  function automatic int own(int p);
    return link[p/2] ? (p & ~1) : p;
  endfunction

  function automatic int weff(int p);
    int w;
    w = wt[own(p)];
    return (w == 0) ? 1 : w;
  endfunction

  // Computes the outcome of the inputs now applied and advances the model.
  task automatic model_eval();
    bit cand [NP];
    int lvl, win;
    bit any_cr;
    lvl = 4;
    for (int p = 0; p < NP; p++) begin
      cand[p] = req[p] && !gprev[p];
      if (cand[p] && prio[p] < lvl) lvl = prio[p];
    end
    e_valid = 1'b0;
    e_port = 0;
    if (full || lvl == 4) begin
      for (int p = 0; p < NP; p++) gprev[p] = 1'b0;
      return;
    end
    for (int p = 0; p < NP; p++) if (cand[p] && prio[p] != lvl) cand[p] = 1'b0;
    any_cr = 1'b0;
    for (int p = 0; p < NP; p++) if (cand[p] && cred[own(p)] > 0) any_cr = 1'b1;
    win = -1;
    for (int p = 0; p < NP; p++) begin
      if (cand[p] && (!any_cr || cred[own(p)] > 0)) begin
        if (win < 0 || weff(p) > weff(win) ||
            (weff(p) == weff(win) && rank[p] < rank[win])) win = p;
      end
    end
    if (!any_cr) begin
      for (int p = 0; p < NP; p++) if (cand[p]) cred[own(p)] = weff(p);
    end
    cred[own(win)] = cred[own(win)] - 1;
    for (int p = 0; p < NP; p++) gprev[p] = (p == win);
    e_valid = 1'b1;
    e_port = win;
    e_cmd = cmd[win];
  endtask

  task automatic apply(input string tag);
    logic [3:0] e_gnt;
    bit ok;
    model_eval();
    @(negedge clk);
    e_gnt = e_valid ? (4'b1 << e_port) : 4'b0;
    ok = (gnt === e_gnt) && (out_valid === e_valid) &&
         (!e_valid || (out_port === 2'(e_port) && out_cmd === e_cmd));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: gnt=%b valid=%b port=%0d cmd=%h expected gnt=%b valid=%b port=%0d cmd=%h",
               tag, gnt, out_valid, out_port, out_cmd, e_gnt, e_valid, e_port, e_cmd);
    end
  endtask

  task automatic set_all(input logic [3:0] r, input logic [1:0] pr);
    req = r;
    for (int i = 0; i < NP; i++) prio[i] = pr;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      prio[i] = '0; cmd[i] = 16'(16'hA000 + i); wt[i] = 8'd1; rank[i] = 2'(i);
      cred[i] = 0; gprev[i] = 1'b0;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    checks++;
    if (gnt !== 4'b0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: gnt=%b valid=%b expected gnt=0000 valid=0", gnt, out_valid);
    end
    // R11: nothing requested
    set_all(4'b0000, 2'd0); apply("R11 idle");
    // R2: single request forwarded with its command
    set_all(4'b0100, 2'd1); cmd[2] = 16'h5A5A; apply("R2 single");
    // R10: held request is skipped while its grant shows
    apply("R10 masked"); apply("R10 regrant"); req = '0; apply("R10 drop");
    // R3: full blocks and freezes
    set_all(4'b0011, 2'd2); full = 1'b1; apply("R3 full"); apply("R3 full");
    full = 1'b0; apply("R3 release"); apply("R3 after");
    // R4: most urgent level wins
    set_all(4'b1001, 2'd3); prio[3] = 2'd0; apply("R4 level");
    req = '0; apply("R4 gap");
    // R6: larger weight first (fresh reset of counters via new request mix)
    wt[0] = 8'd3; wt[1] = 8'd5; set_all(4'b0011, 2'd1);
    for (int k = 0; k < 6; k++) apply("R6 weight");
    // R5: credits drain then reload
    wt[0] = 8'd2; wt[1] = 8'd2; wt[2] = 8'd1; set_all(4'b0111, 2'd0);
    for (int k = 0; k < 10; k++) apply("R5 credit");
    // R7: equal weights, rank decides
    wt[0] = 8'd4; wt[1] = 8'd4; wt[2] = 8'd4; wt[3] = 8'd4;
    rank[0] = 2'd3; rank[1] = 2'd2; rank[2] = 2'd0; rank[3] = 2'd1;
    set_all(4'b1111, 2'd2); for (int k = 0; k < 8; k++) apply("R7 rank");
    // R8: weight zero behaves as one
    wt[0] = 8'd0; wt[1] = 8'd1; rank[0] = 2'd0; rank[1] = 2'd1;
    set_all(4'b0011, 2'd1); for (int k = 0; k < 6; k++) apply("R8 zero");
    // R9: linked pairs share a budget
    link = 2'b11; wt[0] = 8'd3; wt[1] = 8'd9; wt[2] = 8'd1; wt[3] = 8'd7;
    set_all(4'b1111, 2'd1); for (int k = 0; k < 12; k++) apply("R9 link");
    // Random mix, all requirements
    for (int k = 0; k < 3000; k++) begin
      req  = 4'($urandom);
      full = ($urandom % 5) == 0;
      for (int i = 0; i < NP; i++) begin
        prio[i] = 2'($urandom);
        cmd[i]  = 16'($urandom);
        if ((k % 50) == 0) begin
          wt[i] = 8'($urandom % 6);
          rank[i] = 2'($urandom);
        end
      end
      if ((k % 200) == 0) link = 2'($urandom);
      apply("R2 R4 R5 R6 R7 R9 R10 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule